// File: doc/BRIEF.md
# UART Receive FIFO With Status

This block sits between a serial deserializer and a register interface. Each received character arrives as a one-cycle strobe carrying eight data bits and three line-error flags: break, framing error and parity error. The block stores the character and its flags together in a 16-entry FIFO, so the error indication always belongs to the character it arrived with. Software reads a status word that gives the fill count, an empty indication, the error flags of the character at the head, a sticky overrun flag, and two interrupt-status bits: one for the receive fill level and one for a receive timeout.

Three writable registers control the block. A line-control register selects 8-bit or 7-bit character storage. A FIFO-control register selects the receive trigger level, flushes the FIFO, and starts a self-clearing soft reset. Writing the status register clears interrupt-status bits, but only those written as zero. Reading the data register removes the head character.

Register select codes on `reg_sel`: 0 line control, 1 FIFO control, 2 status, 3 receive data. All reads are combinational from the current state. A read pops the FIFO only when `reg_rd` is high with select 3.

Top module: `rx_fifo_stat`

## Requirements
- R1: After reset the status register reads 16'h4000 (empty bit 14 set, count 0, all flags clear), and both control registers read 0.
- R2: Characters leave the FIFO in arrival order, and status bits 4:0 give the number stored. Status bit 14 reads 1 exactly when that number is 0.
- R3: Status bits 15 (break), 13 (framing) and 12 (parity) show the flags stored with the head character, and read 0 when the FIFO is empty.
- R4: A character that arrives while 16 are stored and none is being read is dropped, the stored contents do not change, and overrun (status bit 11) is set.
- R5: FIFO-control bits 8:7 select a trigger level: 0 means 1, 1 means 4, 2 means 8, 3 means 12 characters. Receive-data status (bit 7) is set when a write into the FIFO brings the count to or above that level, and not before.
- R6: Writing the status register clears each of bits 11, 9 and 7 that is written 0. A bit written 1 keeps its value.
- R7: Timeout status (bit 9) is set when the FIFO holds data and no character has been written or read for 4 character times (4 x CHAR_CLKS cycles). It never sets while the FIFO is empty.
- R8: A FIFO-control write with both bit 0 and bit 1 set empties the FIFO. A write with only one of the two set leaves the contents in place.
- R9: Writing FIFO-control bit 15 starts a soft reset. Bit 15 reads 1 for RST_CLKS cycles and then clears itself. During that time incoming characters are ignored. Afterwards the FIFO is empty, all status flags are clear, and both control registers read 0.
- R10: With line-control bits 1:0 = 01 the stored data has bit 7 forced to 0. With 00, all eight bits are stored.
- R11: Reading the data register while the FIFO is empty returns 0 and changes neither the count nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a character is present |
| rx_data | input | 8 | Received character |
| rx_brk | input | 1 | Break detected with this character |
| rx_fer | input | 1 | Framing error with this character |
| rx_per | input | 1 | Parity error with this character |
| reg_sel | input | 2 | Register select: 0 line, 1 FIFO control, 2 status, 3 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO on select 3) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |

## Verification
Overrun is the hardest condition to reach. It needs 16 characters stored, then one more arriving in a cycle with no read. The bench therefore fills the FIFO without reading, sends one extra character, and then drains all 16 entries to show that the extra one never got in.

The timeout check needs a long quiet window, with no arrivals and no reads, after exactly one character is stored. The bench samples just before and just after the 4-character-time boundary.

The soft-reset window is also checked: a character offered during the reset window must vanish.

// File: rtl/rx_fifo_stat.sv
module rx_fifo_stat #(
  parameter int DEPTH      = 16,
  parameter int CHAR_CLKS  = 16,
  parameter int TOUT_CHARS = 4,
  parameter int RST_CLKS   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_brk,
  input  logic        rx_fer,
  input  logic        rx_per,
  input  logic [1:0]  reg_sel,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata
);
  localparam int AW        = $clog2(DEPTH);
  localparam int CW        = AW + 1;
  localparam int EW        = 11;
  localparam int TOUT_CLKS = CHAR_CLKS * TOUT_CHARS;
  localparam int TW        = $clog2(TOUT_CLKS + 1);
  localparam int RW        = $clog2(RST_CLKS + 1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count, count_nx, trig_lvl;
  logic [1:0]    lmode, trig_code, frst;
  logic          ovr, rdis, tout;
  logic [TW-1:0] idle;
  logic [RW-1:0] srst_cnt;
  logic [EW-1:0] head, entry;

  wire unused_wbits = ^{reg_wdata[14:12], reg_wdata[10], reg_wdata[6:2]};

  wire busy    = srst_cnt != '0;
  wire wr_lc   = reg_wr && reg_sel == 2'd0 && !busy;
  wire wr_fc   = reg_wr && reg_sel == 2'd1 && !busy;
  wire wr_st   = reg_wr && reg_sel == 2'd2 && !busy;
  wire srst_go = wr_fc && reg_wdata[15];
  wire flush   = wr_fc && reg_wdata[0] && reg_wdata[1];
  wire clr     = srst_go || busy || flush;
  wire empty   = count == '0;
  wire full    = count == CW'(DEPTH);
  wire pop     = reg_rd && reg_sel == 2'd3 && !empty && !busy;
  wire push    = rx_valid && (!full || pop) && !clr;
  wire drop    = rx_valid && full && !pop && !clr;

  assign count_nx = count + CW'(push) - CW'(pop);

  always_comb begin
    case (trig_code)
      2'd0:    trig_lvl = CW'(1);
      2'd1:    trig_lvl = CW'(4);
      2'd2:    trig_lvl = CW'(8);
      default: trig_lvl = CW'(12);
    endcase
  end

  wire rdis_set = push && count_nx >= trig_lvl;
  wire tout_hit = !empty && !push && !pop && !clr && idle == TW'(TOUT_CLKS - 1);

  assign entry = {rx_brk, rx_fer, rx_per,
                  (lmode == 2'b01) ? {1'b0, rx_data[6:0]} : rx_data};
  assign head  = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
      lmode <= '0; trig_code <= '0; frst <= '0;
      ovr <= 1'b0; rdis <= 1'b0; tout <= 1'b0;
      idle <= '0; srst_cnt <= '0;
    end else begin
      if (srst_go)   srst_cnt <= RW'(RST_CLKS);
      else if (busy) srst_cnt <= srst_cnt - 1'b1;

      if (wr_lc) lmode <= reg_wdata[1:0];
      if (wr_fc) begin
        trig_code <= reg_wdata[8:7];
        frst      <= reg_wdata[1:0];
      end

      if (clr) begin
        wp <= '0; rp <= '0; count <= '0;
      end else begin
        if (push) wp <= wp + 1'b1;
        if (pop)  rp <= rp + 1'b1;
        count <= count_nx;
      end

      if (clr || push || pop || empty)  idle <= '0;
      else if (idle != TW'(TOUT_CLKS))  idle <= idle + 1'b1;

      ovr  <= drop     || (ovr  && !(wr_st && !reg_wdata[11]));
      rdis <= rdis_set || (rdis && !(wr_st && !reg_wdata[7]));
      tout <= tout_hit || (tout && !(wr_st && !reg_wdata[9]));

      if (srst_go || busy) begin
        lmode <= '0; trig_code <= '0; frst <= '0;
        ovr <= 1'b0; rdis <= 1'b0; tout <= 1'b0;
      end
    end
  end

  wire [15:0] stat_word = {head[10], empty, head[9], head[8], ovr, 1'b0, tout,
                           1'b0, rdis, 2'b00, 5'(count)};
  wire [15:0] fc_word   = {busy, 6'b0, trig_code, 5'b0, frst};

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {14'b0, lmode};
      2'd1:    reg_rdata = fc_word;
      2'd2:    reg_rdata = stat_word;
      default: reg_rdata = {8'b0, head[7:0]};
    endcase
  end
endmodule

// File: rtl/rx_fifo_stat_chk.sv
module rx_fifo_stat_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          pop,
  input logic          clr,
  input logic          busy,
  input logic [CW-1:0] count,
  input logic          ovr,
  input logic          rdis,
  input logic          tout,
  input logic          wr_st,
  input logic [15:0]   wdata
);
  p_count_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && count < CW'(DEPTH) && !pop && !clr |=> count == $past(count) + 1'b1);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && count == CW'(DEPTH) && !pop && !clr |=> count == CW'(DEPTH) && ovr);

  p_rdis_from_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdis) |-> $past(rx_valid));

  p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !clr && !(wr_st && !wdata[11]) |=> ovr);

  p_tout_needs_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tout) |-> $past(count) != '0);

  p_busy_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> count == '0);
endmodule

bind rx_fifo_stat rx_fifo_stat_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .pop(pop), .clr(clr),
  .busy(busy), .count(count), .ovr(ovr), .rdis(rdis), .tout(tout),
  .wr_st(wr_st), .wdata(reg_wdata));

// File: tb/rx_fifo_stat_tb.sv
module rx_fifo_stat_tb;
  localparam int T_OUT = 64;
  localparam int RSTC  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_brk = 1'b0, rx_fer = 1'b0, rx_per = 1'b0;
  logic [7:0] rx_data = '0;
  logic [1:0] reg_sel = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;

  int checks = 0, fails = 0;
  logic [10:0] exp_q[$];
  logic [15:0] v;

  always #5 clk = ~clk;

  rx_fifo_stat u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_brk(rx_brk), .rx_fer(rx_fer), .rx_per(rx_per), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] d);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  // driver: offers a character and records what should come out
  task automatic send(input logic [7:0] d, input logic b, input logic f, input logic p,
                      input logic seven, input logic expect_drop);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_brk = b; rx_fer = f; rx_per = p;
    if (!expect_drop) exp_q.push_back({b, f, p, seven ? {1'b0, d[6:0]} : d});
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // monitor: compares head flags and data against the scoreboard, then pops
  task automatic take(input string tag);
    logic [10:0] e;
    logic [15:0] s;
    e = exp_q.pop_front();
    rd(2'd2, s);
    chk({tag, " head flags"}, {13'b0, s[15], s[13], s[12]}, {13'b0, e[10:8]});
    reg_sel = 2'd3; reg_rd = 1'b1;
    #1 chk({tag, " data"}, reg_rdata, {8'b0, e[7:0]});
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd2, v); chk("R1 status after reset", v, 16'h4000);
    rd(2'd1, v); chk("R1 fifo ctrl after reset", v, 16'h0000);
    rd(2'd0, v); chk("R1 line ctrl after reset", v, 16'h0000);

    send(8'h31, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    send(8'hC2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    send(8'h53, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    send(8'h04, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    send(8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    rd(2'd2, v); chk("R2 count five", {11'b0, v[4:0]}, 16'd5);
    chk("R2 not empty", {15'b0, v[14]}, 16'd0);
    for (int i = 0; i < 5; i++) take("R2 R3 order");
    rd(2'd2, v); chk("R2 empty again", {v[15:12], 7'b0, v[4:0]}, 16'h4000);
    chk("R3 flags zero when empty", {13'b0, v[15], v[13], v[12]}, 16'd0);

    wr(2'd0, 16'h0001);
    send(8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    wr(2'd0, 16'h0000);
    send(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    take("R10 seven-bit");
    take("R10 eight-bit");

    for (int c = 0; c < 4; c++) begin
      int lvl;
      lvl = (c == 0) ? 1 : c * 4;
      wr(2'd1, 16'(c) << 7);
      wr(2'd2, 16'h0000);
      for (int k = 0; k < lvl - 1; k++) send(8'(k), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      rd(2'd2, v); chk("R5 below trigger", {15'b0, v[7]}, 16'd0);
      send(8'h77, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      rd(2'd2, v); chk("R5 at trigger", {15'b0, v[7]}, 16'd1);
      wr(2'd1, (16'(c) << 7) | 16'h0003);
      exp_q.delete();
      rd(2'd2, v); chk("R8 flush empties", {11'b0, v[4:0]}, 16'd0);
    end

    wr(2'd1, 16'h0000);
    send(8'h10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    send(8'h20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    wr(2'd1, 16'h0001);
    rd(2'd2, v); chk("R8 bit0 alone keeps data", {11'b0, v[4:0]}, 16'd2);
    wr(2'd1, 16'h0002);
    rd(2'd2, v); chk("R8 bit1 alone keeps data", {11'b0, v[4:0]}, 16'd2);
    wr(2'd1, 16'h0000);
    take("R8 survivor");
    take("R8 survivor");

    rd(2'd3, v); chk("R11 empty read returns 0", v, 16'h0000);
    reg_rd = 1'b1; @(negedge clk); reg_rd = 1'b0;
    rd(2'd2, v); chk("R11 count unchanged", {11'b0, v[4:0]}, 16'd0);

    wr(2'd2, 16'h0000);
    for (int i = 0; i < 16; i++) send(8'(i * 17), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    send(8'hEE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    rd(2'd2, v); chk("R4 count stays 16", {11'b0, v[4:0]}, 16'd16);
    chk("R4 overrun set", {15'b0, v[11]}, 16'd1);
    wr(2'd2, 16'hFFFF);
    rd(2'd2, v); chk("R6 write ones keeps flags", {v[11], 3'b0, v[7]}, 5'b10001);
    wr(2'd2, 16'hF7FF);
    rd(2'd2, v); chk("R6 zero clears only overrun", {v[11], 3'b0, v[7]}, 5'b00001);
    for (int i = 0; i < 16; i++) take("R4 drain order");
    wr(2'd2, 16'hFF7F);
    rd(2'd2, v); chk("R6 zero clears receive status", {15'b0, v[7]}, 16'd0);

    wr(2'd2, 16'h0000);
    repeat (T_OUT + 4) @(negedge clk);
    rd(2'd2, v); chk("R7 no timeout when empty", {15'b0, v[9]}, 16'd0);
    send(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (T_OUT - 2) @(negedge clk);
    rd(2'd2, v); chk("R7 timeout not yet", {15'b0, v[9]}, 16'd0);
    repeat (3) @(negedge clk);
    rd(2'd2, v); chk("R7 timeout set", {15'b0, v[9]}, 16'd1);
    wr(2'd2, 16'hFDFF);
    rd(2'd2, v); chk("R6 R7 timeout cleared", {15'b0, v[9]}, 16'd0);
    take("R7 char");

    wr(2'd0, 16'h0001);
    send(8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    send(8'h02, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    reg_sel = 2'd1; reg_wdata = 16'h8100; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    exp_q.delete();
    rd(2'd1, v); chk("R9 reset busy", {15'b0, v[15]}, 16'd1);
    send(8'h99, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (RSTC) @(negedge clk);
    rd(2'd1, v); chk("R9 busy cleared and ctrl default", v, 16'h0000);
    rd(2'd2, v); chk("R9 status after soft reset", v, 16'h4000);
    rd(2'd0, v); chk("R9 line ctrl default", v, 16'h0000);

    finish_up();
  end
endmodule